// File: doc/BRIEF.md
# Quadrature Encoder and Edge Counter

This block counts events on two external inputs and keeps the result in a free-running register. In edge-counting mode only input A matters: every selected edge of A adds one. In quadrature mode the block turns the two phase-shifted inputs A and B into up and down steps. The direction of each step comes from which input moved, which way it moved and the level of the other input at that moment.

The counter runs continuously between zero and a programmable ceiling and wraps at either end. Software uses a small word-wide register port to reach the control, configuration, count, ceiling, compare, status and flag-clear registers. The mode and the edge selection may be changed only while the block is off. The ceiling and compare values may be written only while it is on. Each accepted ceiling or compare write raises a ready flag a fixed number of cycles later, and software lowers the flag through the clear register. Counting begins when a start bit is written after enable is already set.

Top module: `lpenc_counter`

## Requirements
- R1: After reset the control (address 0), configuration (address 1), count (address 2), compare (address 4) and status (address 5) registers read zero, and the ceiling register (address 3) reads all ones.
- R2: With configuration bit 2 clear (edge-counting mode), the count rises by one on each selected edge of input A. The selection is configuration bits [1:0]: 0 selects rising edges, 1 falling, 2 both, and 3 none. Input B has no effect in this mode.
- R3: In quadrature mode (configuration bit 2 set) with selection 0, a rise of A steps down when B is high and up when B is low. A rise of B steps up when A is high and down when A is low. Falling edges make no step.
- R4: In quadrature mode with selection 1, a fall of A steps up when B is high and down when B is low. A fall of B steps down when A is high and up when A is low. Rising edges make no step.
- R5: In quadrature mode with selection 2, the rules of R3 and R4 both apply, so one full forward quadrature cycle adds four. With selection 0, the same cycle adds two.
- R6: In quadrature mode, when A and B both change in the same synchronised cycle, no step is made.
- R7: A step up from a count at or above the ceiling gives zero. A step down from zero gives the ceiling.
- R8: Writes to the ceiling register (address 3) and the compare register (address 4) are accepted only while enable is set. Otherwise they are ignored.
- R9: An accepted ceiling write sets status bit 0, and an accepted compare write sets status bit 1. The flag is set by the second rising clock edge after the edge that takes the write.
- R10: Writing a 1 to bit 0 or bit 1 of the clear register (address 6) lowers the status flag at the same position. A zero bit leaves that flag alone.
- R11: Control bit 0 is enable and control bit 1 is start. Start takes effect only if enable was already set before the write. Until start takes effect, the count holds its value. The control register reads back as {running, enable} in bits [1:0].
- R12: Clearing enable stops counting, and the count reads zero from the next cycle onward. Writes to the count register are ignored.
- R13: Writes to the configuration register are ignored while enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | 1 | Asynchronous input A (edge source in edge-counting mode) |
| in_b | input | 1 | Asynchronous input B (second quadrature phase) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Read data of the addressed register (combinational) |

## Verification
An input change has to pass two synchroniser flops and the edge-history flop before it moves the count. The count therefore changes on the third rising edge after the change. The bench drives each input change at a falling edge, waits three rising edges and reads the count at the next falling edge. A register write takes effect at the edge that samples the strobe, so it is read back at the falling edge right after it. The ready flags are checked at three points: after the write edge and after the following edge (both still low), then after the second edge (set). The clearing of the count after disable is read one edge after the disabling write.

// File: rtl/lpenc_pkg.sv
package lpenc_pkg;

   localparam int ADDR_W = 3;

   // register addresses
   localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] RA_CFG    = 3'd1;
   localparam logic [ADDR_W-1:0] RA_COUNT  = 3'd2;
   localparam logic [ADDR_W-1:0] RA_RELOAD = 3'd3;
   localparam logic [ADDR_W-1:0] RA_CMP    = 3'd4;
   localparam logic [ADDR_W-1:0] RA_STAT   = 3'd5;
   localparam logic [ADDR_W-1:0] RA_CLR    = 3'd6;

   // bit positions
   localparam int CTL_EN  = 0;
   localparam int CTL_GO  = 1;
   localparam int FLG_RLD = 0;
   localparam int FLG_CMP = 1;
   localparam int CFG_W   = 3;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_OFF  = 2'd3
   } edge_sel_e;

   typedef struct packed {
      logic      quad;
      edge_sel_e edge_sel;
   } cfg_t;

endpackage

// File: rtl/lpenc_sync.sv
module lpenc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/lpenc_decode.sv
module lpenc_decode
   import lpenc_pkg::*;
#(
   parameter bit ENC_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      a,
   input  logic      b,
   input  logic      quad,
   input  edge_sel_e edge_sel,
   output logic      up,
   output logic      dn
);

   logic a_q, b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= a;
         b_q <= b;
      end
   end

   logic rise_a, fall_a, rise_b, fall_b;
   logic use_rise, use_fall;

   assign rise_a   =  a & ~a_q;
   assign fall_a   = ~a &  a_q;
   assign rise_b   =  b & ~b_q;
   assign fall_b   = ~b &  b_q;
   assign use_rise = (edge_sel == EDGE_RISE) || (edge_sel == EDGE_BOTH);
   assign use_fall = (edge_sel == EDGE_FALL) || (edge_sel == EDGE_BOTH);

   logic cnt_up;
   assign cnt_up = (rise_a & use_rise) | (fall_a & use_fall);

   generate
      if (ENC_EN) begin : g_quad
         logic q_up, q_dn, clash;
         assign clash = (a ^ a_q) & (b ^ b_q);
         always_comb begin
            q_up = (use_rise & ((rise_a & ~b) | (rise_b &  a)))
                 | (use_fall & ((fall_a &  b) | (fall_b & ~a)));
            q_dn = (use_rise & ((rise_a &  b) | (rise_b & ~a)))
                 | (use_fall & ((fall_a & ~b) | (fall_b &  a)));
            if (!quad) begin
               up = cnt_up;
               dn = 1'b0;
            end else if (clash) begin
               up = 1'b0;
               dn = 1'b0;
            end else begin
               up = q_up;
               dn = q_dn;
            end
         end
      end else begin : g_plain
         logic unused_quad;
         assign unused_quad = quad ^ b_q ^ rise_b ^ fall_b;
         assign up = cnt_up;
         assign dn = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/lpenc_regs.sv
module lpenc_regs
   import lpenc_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int READY_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  rdata,
   output logic              en_q,
   output logic              run_q,
   output cfg_t              cfg_q,
   output logic [CNT_W-1:0]  reload_q,
   output logic [1:0]        wr_ok,
   output logic [1:0]        rdy
);

   logic             wr_ctrl, wr_cfg, wr_clr;
   logic [CNT_W-1:0] cmp_q;

   assign wr_ctrl              = we && (addr == RA_CTRL);
   assign wr_cfg               = we && (addr == RA_CFG) && !en_q;
   assign wr_clr               = we && (addr == RA_CLR);
   assign wr_ok[FLG_RLD]       = we && (addr == RA_RELOAD) && en_q;
   assign wr_ok[FLG_CMP]       = we && (addr == RA_CMP) && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         run_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q  <= wdata[CTL_EN];
         run_q <= wdata[CTL_EN] & (run_q | (en_q & wdata[CTL_GO]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_cfg) cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         cmp_q    <= '0;
      end else begin
         if (wr_ok[FLG_RLD]) reload_q <= wdata;
         if (wr_ok[FLG_CMP]) cmp_q    <= wdata;
      end
   end

   // ready flags: fixed delay from accepted write, cleared by write-one
   for (genvar k = 0; k < 2; k++) begin : g_rdy
      logic [READY_LAT-1:0] dly;
      logic                 flag;
      if (READY_LAT == 1) begin : g_d1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly <= '0;
            else        dly <= wr_ok[k];
         end
      end else begin : g_dn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly <= '0;
            else        dly <= {dly[READY_LAT-2:0], wr_ok[k]};
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag <= 1'b0;
         else        flag <= (flag & ~(wr_clr & wdata[k])) | dly[READY_LAT-1];
      end
      assign rdy[k] = flag;
   end

   always_comb begin
      case (addr)
         RA_CTRL:   rdata = {{(CNT_W-2){1'b0}}, run_q, en_q};
         RA_CFG:    rdata = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
         RA_COUNT:  rdata = count;
         RA_RELOAD: rdata = reload_q;
         RA_CMP:    rdata = cmp_q;
         RA_STAT:   rdata = {{(CNT_W-2){1'b0}}, rdy};
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/lpenc_core.sv
module lpenc_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             run,
   input  logic             up,
   input  logic             dn,
   input  logic [CNT_W-1:0] ceil_v,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (!en) begin
         count <= '0;
      end else if (run && up) begin
         count <= (count >= ceil_v) ? '0 : count + 1'b1;
      end else if (run && dn) begin
         count <= (count == '0) ? ceil_v : count - 1'b1;
      end
   end

endmodule

// File: rtl/lpenc_counter.sv
module lpenc_counter
   import lpenc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int READY_LAT   = 2,
   parameter bit ENC_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_a,
   input  logic              in_b,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata
);

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("lpenc_counter: CNT_W must be at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("lpenc_counter: SYNC_STAGES must be at least 1");
      end
      if (READY_LAT < 1) begin : g_bad_lat
         $error("lpenc_counter: READY_LAT must be at least 1");
      end
   endgenerate

   logic [1:0]       sync_q;
   logic             up_w, dn_w, en_w, run_w;
   cfg_t             cfg_w;
   logic [CNT_W-1:0] count_w, reload_w;
   logic [1:0]       ok_w, rdy_w;

   lpenc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({in_b, in_a}),
      .q     (sync_q)
   );

   lpenc_decode #(.ENC_EN(ENC_EN)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .a        (sync_q[0]),
      .b        (sync_q[1]),
      .quad     (cfg_w.quad),
      .edge_sel (cfg_w.edge_sel),
      .up       (up_w),
      .dn       (dn_w)
   );

   lpenc_regs #(.CNT_W(CNT_W), .READY_LAT(READY_LAT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .count    (count_w),
      .rdata    (bus_rdata),
      .en_q     (en_w),
      .run_q    (run_w),
      .cfg_q    (cfg_w),
      .reload_q (reload_w),
      .wr_ok    (ok_w),
      .rdy      (rdy_w)
   );

   lpenc_core #(.CNT_W(CNT_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_w),
      .run    (run_w),
      .up     (up_w),
      .dn     (dn_w),
      .ceil_v (reload_w),
      .count  (count_w)
   );

endmodule

// File: rtl/lpenc_checker.sv
module lpenc_checker #(
   parameter int CNT_W     = 16,
   parameter int READY_LAT = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_q,
   input logic             run_q,
   input logic             step_up,
   input logic             step_dn,
   input logic [CNT_W-1:0] count_q,
   input logic [CNT_W-1:0] reload_q,
   input logic [2:0]       cfg_q,
   input logic [1:0]       wr_ok,
   input logic [1:0]       rdy
);

   // R6: the decoder never asks for both directions at once
   p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_up && step_dn));

   // R6: without a step the enabled count holds
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !step_up && !step_dn) |=> $stable(count_q));

   p_wait_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !run_q) |=> $stable(count_q));

   p_off_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (count_q == '0));

   p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && run_q && step_up && count_q == reload_q) |=> (count_q == '0));

   p_wrap_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && run_q && step_dn && count_q == '0) |=> (count_q == $past(reload_q)));

   p_cfg_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> $stable(cfg_q));

   p_ceil_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> $stable(reload_q));

   generate
      if (READY_LAT == 2) begin : g_lat2
         p_rld_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy[0]) |-> $past(wr_ok[0], 3));
         p_cmp_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rdy[1]) |-> $past(wr_ok[1], 3));
      end
   endgenerate

endmodule

bind lpenc_counter lpenc_checker #(.CNT_W(CNT_W), .READY_LAT(READY_LAT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_q     (en_w),
   .run_q    (run_w),
   .step_up  (up_w),
   .step_dn  (dn_w),
   .count_q  (count_w),
   .reload_q (reload_w),
   .cfg_q    (cfg_w),
   .wr_ok    (ok_w),
   .rdy      (rdy_w)
);

// File: tb/sim_lpenc_counter.sv
module sim_lpenc_counter;

   localparam int CLK_T = 10;
   localparam int W     = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_a = 1'b0;
   logic         in_b = 1'b0;
   logic         bus_we = 1'b0;
   logic [2:0]   bus_addr = 3'd0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // bench model
   int   mcnt = 0;
   int   mrld = 32'hFFFF;
   bit   ma = 1'b0, mb = 1'b0;
   bit   menc = 1'b0;
   bit [1:0] mpol = 2'd0;
   int unsigned seed_dummy;

   lpenc_counter u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_a      (in_a),
      .in_b      (in_b),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   always #(CLK_T/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input int d);
      bus_we    = 1'b1;
      bus_addr  = a;
      bus_wdata = d[W-1:0];
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   // expected step from the direction rules: +1, -1 or 0
   function automatic int exp_step(bit enc, bit [1:0] pol, bit a0, bit b0, bit a1, bit b1);
      bit ra, fa, rb, fb, rs, fs;
      ra = !a0 && a1;  fa = a0 && !a1;
      rb = !b0 && b1;  fb = b0 && !b1;
      rs = (pol == 2'd0) || (pol == 2'd2);
      fs = (pol == 2'd1) || (pol == 2'd2);
      if (!enc) return ((ra && rs) || (fa && fs)) ? 1 : 0;
      if ((a0 != a1) && (b0 != b1)) return 0;
      if (ra && rs) return b1 ? -1 : 1;
      if (fa && fs) return b1 ? 1 : -1;
      if (rb && rs) return a1 ? 1 : -1;
      if (fb && fs) return a1 ? -1 : 1;
      return 0;
   endfunction

   task automatic apply(input bit na, input bit nb, input string tag);
      int s, v;
      s = exp_step(menc, mpol, ma, mb, na, nb);
      in_a = na;
      in_b = nb;
      ma = na;
      mb = nb;
      if (s > 0)      mcnt = (mcnt >= mrld) ? 0 : mcnt + 1;
      else if (s < 0) mcnt = (mcnt == 0) ? mrld : mcnt - 1;
      tick(3);
      rd(3'd2, v);
      chk(tag, v, mcnt);
   endtask

   task automatic set_mode(input bit enc, input bit [1:0] pol);
      int v;
      wr(3'd0, 0);
      tick(1);
      rd(3'd2, v);
      chk("R12 count cleared on disable", v, 0);
      in_a = 1'b0;
      in_b = 1'b0;
      ma = 1'b0;
      mb = 1'b0;
      tick(4);
      wr(3'd1, {29'd0, enc, pol});
      wr(3'd0, 1);
      wr(3'd0, 3);
      menc = enc;
      mpol = pol;
      mcnt = 0;
   endtask

   task automatic rand_run(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         int op;
         op = int'($urandom % 4);
         apply(ma ^ (op == 0 || op == 2), mb ^ (op == 1 || op == 2), tag);
      end
   endtask

   initial begin
      #(CLK_T * 100000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog (all requirements) act=timeout exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;
      seed_dummy = $urandom(32'd2024);
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R1 reset values
      rd(3'd0, v); chk("R1 ctrl", v, 0);
      rd(3'd1, v); chk("R1 cfg", v, 0);
      rd(3'd2, v); chk("R1 count", v, 0);
      rd(3'd3, v); chk("R1 ceiling", v, 32'hFFFF);
      rd(3'd4, v); chk("R1 compare", v, 0);
      rd(3'd5, v); chk("R1 status", v, 0);

      // R8 writes while disabled are dropped
      wr(3'd3, 7);
      wr(3'd4, 9);
      tick(3);
      rd(3'd3, v); chk("R8 ceiling unchanged", v, 32'hFFFF);
      rd(3'd4, v); chk("R8 compare unchanged", v, 0);
      rd(3'd5, v); chk("R8 no flag", v, 0);

      // R11 start without enable is ignored
      wr(3'd0, 2);
      rd(3'd0, v); chk("R11 start alone", v, 0);
      wr(3'd1, 0);
      wr(3'd0, 1);
      rd(3'd0, v); chk("R11 enabled not running", v, 1);
      in_a = 1'b1; ma = 1'b1;
      tick(3);
      rd(3'd2, v); chk("R11 count frozen before start", v, 0);
      wr(3'd0, 3);
      rd(3'd0, v); chk("R11 running", v, 3);

      // R9 ready latency
      wr(3'd3, 5);
      mrld = 5;
      rd(3'd5, v); chk("R9 flag low after write edge", v & 1, 0);
      tick(1);
      rd(3'd5, v); chk("R9 flag low one edge later", v & 1, 0);
      tick(1);
      rd(3'd5, v); chk("R9 flag set two edges later", v & 1, 1);
      rd(3'd3, v); chk("R8 ceiling accepted", v, 5);
      wr(3'd4, 3);
      tick(3);
      rd(3'd5, v); chk("R9 both flags", v, 3);
      rd(3'd4, v); chk("R8 compare accepted", v, 3);

      // R10 write-one clear
      wr(3'd6, 1);
      rd(3'd5, v); chk("R10 clear ceiling flag", v, 2);
      wr(3'd6, 2);
      rd(3'd5, v); chk("R10 clear compare flag", v, 0);

      // R13 / R12 ignored writes
      wr(3'd1, 6);
      rd(3'd1, v); chk("R13 cfg locked", v, 0);
      wr(3'd2, 4);
      rd(3'd2, v); chk("R12 count read-only", v, 0);

      // R2 edge-counting mode
      set_mode(1'b0, 2'd0); rand_run(40, "R2 rising");
      set_mode(1'b0, 2'd1); rand_run(40, "R2 falling");
      set_mode(1'b0, 2'd3); rand_run(20, "R2 none");
      set_mode(1'b0, 2'd2);
      for (int i = 0; i < 6; i++) apply(~ma, mb, "R7 wrap up");
      chk("R7 wrapped to zero", mcnt, 0);

      // R3/R4/R6 quadrature random
      set_mode(1'b1, 2'd0); rand_run(60, "R3 quad rising");
      set_mode(1'b1, 2'd1); rand_run(60, "R4 quad falling");
      set_mode(1'b1, 2'd2); rand_run(60, "R6 quad both");

      // R5 directed forward cycle
      set_mode(1'b1, 2'd2);
      apply(1, 0, "R5"); apply(1, 1, "R5"); apply(0, 1, "R5"); apply(0, 0, "R5 x4");
      rd(3'd2, v); chk("R5 four per cycle", v, 4);
      set_mode(1'b1, 2'd0);
      apply(1, 0, "R5"); apply(1, 1, "R5"); apply(0, 1, "R5"); apply(0, 0, "R5 x2");
      rd(3'd2, v); chk("R5 two per cycle", v, 2);
      // reverse cycle, then down through zero
      apply(0, 1, "R3 down"); apply(1, 1, "R3 down"); apply(1, 0, "R3"); apply(0, 0, "R3");
      apply(0, 1, "R7 wrap down");
      rd(3'd2, v); chk("R7 down to ceiling", v, 5);

      // R6 directed simultaneous change
      set_mode(1'b1, 2'd2);
      apply(1, 1, "R6 clash");
      rd(3'd2, v); chk("R6 no count on clash", v, 0);

      // R12 stop: no counting while disabled
      apply(0, 1, "R4");
      wr(3'd0, 0);
      tick(1);
      rd(3'd2, v); chk("R12 cleared", v, 0);
      in_a = 1'b1;
      tick(4);
      rd(3'd2, v); chk("R12 stopped", v, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule